// File: doc/BRIEF.md
# Threshold-Signalling Byte FIFO

This block is a byte-wide FIFO. It sits between a register-mapped host port and a serial bus engine. One data register serves both transfer directions, and a direction field decides who fills the FIFO and who drains it:

- **Transmit direction:** the host pushes bytes through the data register and the engine pops them.
- **Receive direction:** the engine pushes bytes and the host pops them through the same data register.

The block compares its fill level against a programmable receive or transmit threshold and raises a request when the host should service it. It also flags misuse of the data port in sticky status bits that are cleared by writing one to them. The OR of all status bits drives a single level output. A command bit empties the FIFO; it reads back as set until the flush has happened.

The `INCL` parameter picks the comparison. With `INCL`=0 the comparison is strict, so a transmit threshold of 1 means "empty". With `INCL`=1 the comparison includes the threshold value, so a transmit threshold of 0 already means "empty".

Top module: `lvl_req_fifo`

## Requirements
- R1: After reset, all of the following read as zero: level, control, thresholds, status and `irq`. Host addresses are 0 control, 1 thresholds, 2 status, 3 data.
- R2: Bytes leave the FIFO in the order they entered. `level` counts the stored bytes and never exceeds `DEPTH`.
- R3: A host data write in transmit direction while the FIFO holds `DEPTH` bytes does three things: it sets status bit 2 (overflow), it drops the byte, and it leaves `level` unchanged.
- R4: A host data read in receive direction while the FIFO is empty returns 0 and sets status bit 1 (underflow).
- R5: A data-port access against the direction sets status bit 3 (illegal) and has no other effect. Against the direction means a write in receive direction, or a read in transmit direction, which returns 0. Control bit 0 is the direction: 0 = transmit, 1 = receive.
- R6: Writing 1 to control bit 1 empties the FIFO. The bit reads 1 in the cycle after the write, then 0, and `level` is 0 from then on.
- R7: In receive direction, status bit 0 (request) is set one cycle after `level` exceeds the receive threshold (threshold register bits 4:0). With `INCL`=1 it is set when `level` equals or exceeds that threshold.
- R8: In transmit direction, the request bit is set one cycle after `level` is below the transmit threshold (threshold register bits 12:8). With `INCL`=1 it is set when `level` is at or below that threshold.
- R9: Status bits are sticky. Writing the status register clears exactly the bits written as 1 and leaves the others unchanged.
- R10: A request cleared while its condition still holds reads 0 in the cycle after the clear and 1 in the cycle after that.
- R11: `irq` is high whenever any status bit is set.
- R12: The engine pushes only in receive direction and pops only in transmit direction. Engine accesses in the other direction, on a full FIFO (push) or on an empty FIFO (pop) are ignored. `eng_rdata` shows the head byte in transmit direction, else 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe (pops on the data address) |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` |
| eng_push | input | 1 | Engine byte push (receive direction) |
| eng_wdata | input | 8 | Engine byte to push |
| eng_pop | input | 1 | Engine byte pop (transmit direction) |
| eng_rdata | output | 8 | Head byte offered to the engine |
| level | output | $clog2(DEPTH)+1 | Current fill level |
| irq | output | 1 | OR of all status bits |

## Verification
The in-module assertions check the following on every cycle:
- the level bound;
- an empty FIFO right after a flush;
- each error event turning into its sticky bit on the next edge;
- sticky and write-one-to-clear behaviour of the status word.

Only the directed scenarios can show the rest:
- byte ordering across both directions;
- the strict versus inclusive threshold edges, observed on two instances built with different `INCL`;
- the one-cycle readback of the clear command;
- a request re-appearing after it is cleared;
- a dropped byte never surfacing at the engine side.

// File: rtl/lrf_pkg.sv
package lrf_pkg;
    localparam int REG_W      = 16;
    localparam int BYTE_W     = 8;
    localparam int THR_TX_LSB = 8;
    localparam int ST_W       = 4;

    typedef enum logic [1:0] {
        A_CTRL = 2'd0,
        A_THR  = 2'd1,
        A_STAT = 2'd2,
        A_DATA = 2'd3
    } reg_addr_e;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    // bit 0 request, 1 underflow, 2 overflow, 3 illegal
    typedef struct packed {
        logic illegal;
        logic overflow;
        logic underflow;
        logic request;
    } stat_t;

    function automatic logic [REG_W-1:0] zext_byte(input logic [BYTE_W-1:0] b);
        return {{(REG_W-BYTE_W){1'b0}}, b};
    endfunction
endpackage

// File: rtl/lrf_store.sv
module lrf_store
    import lrf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int LW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              push,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [LW-1:0]     count
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wp, rp;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push && !flush) mem[wp] <= wbyte;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) wp <= bump(wp);
            if (pop)  rp <= bump(rp);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head = mem[rp];

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= LW'(DEPTH))
        else $error("level above depth");

    assert_flush_empty_R6: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0))
        else $error("flush did not empty");
endmodule

// File: rtl/lrf_req.sv
module lrf_req
    import lrf_pkg::*;
#(
    parameter int LW   = 5,
    parameter bit INCL = 1'b0
) (
    input  dir_e          dir,
    input  logic [LW-1:0] level,
    input  logic [LW-1:0] rx_thr,
    input  logic [LW-1:0] tx_thr,
    output logic          req
);
    logic rx_hit, tx_hit;

    generate
        if (INCL) begin : g_incl
            assign rx_hit = (level >= rx_thr);
            assign tx_hit = (level <= tx_thr);
        end else begin : g_excl
            assign rx_hit = (level > rx_thr);
            assign tx_hit = (level < tx_thr);
        end
    endgenerate

    assign req = (dir == DIR_RX) ? rx_hit : tx_hit;
endmodule

// File: rtl/lrf_status.sv
module lrf_status
    import lrf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [ST_W-1:0] ev,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_mask,
    output logic [ST_W-1:0] st
);
    logic [ST_W-1:0] keep;

    assign keep = clr_we ? ~clr_mask : '1;

    // a clear wins in its own cycle; a persisting cause sets again next cycle
    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= (st | ev) & keep;
    end

    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((st & $past(clr_mask)) == '0))
        else $error("cleared bit still set");

    assert_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        !clr_we |=> ((st & $past(st)) == $past(st)))
        else $error("status bit fell without clear");
endmodule

// File: rtl/lvl_req_fifo.sv
module lvl_req_fifo
    import lrf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter bit INCL  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       host_we,
    input  logic                       host_re,
    input  logic [1:0]                 host_addr,
    input  logic [REG_W-1:0]           host_wdata,
    output logic [REG_W-1:0]           host_rdata,
    input  logic                       eng_push,
    input  logic [BYTE_W-1:0]          eng_wdata,
    input  logic                       eng_pop,
    output logic [BYTE_W-1:0]          eng_rdata,
    output logic [$clog2(DEPTH):0]     level,
    output logic                       irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int LW = AW + 1;

    reg_addr_e       addr;
    dir_e            dir_q;
    logic            clr_q;
    logic [LW-1:0]   rx_thr_q, tx_thr_q;
    logic            full, empty, data_wr, data_rd, stat_wr;
    logic            push, pop, req_now;
    logic            ill_ev, ovf_ev, udf_ev;
    logic [BYTE_W-1:0] wbyte, head;
    logic [ST_W-1:0] st_bits;
    stat_t           ev, st;
    logic            unused_wbits;

    assign unused_wbits = ^host_wdata;
    assign addr    = reg_addr_e'(host_addr);
    assign full    = (level == LW'(DEPTH));
    assign empty   = (level == '0);
    assign data_wr = host_we && addr == A_DATA && !clr_q;
    assign data_rd = host_re && addr == A_DATA && !clr_q;
    assign stat_wr = host_we && addr == A_STAT;

    assign ill_ev = (data_wr && dir_q == DIR_RX) || (data_rd && dir_q == DIR_TX);
    assign ovf_ev = data_wr && dir_q == DIR_TX && full;
    assign udf_ev = data_rd && dir_q == DIR_RX && empty;

    assign push  = !clr_q && !full &&
                   ((dir_q == DIR_TX) ? data_wr : eng_push);
    assign pop   = !clr_q && !empty &&
                   ((dir_q == DIR_RX) ? data_rd : eng_pop);
    assign wbyte = (dir_q == DIR_TX) ? host_wdata[BYTE_W-1:0] : eng_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q    <= DIR_TX;
            clr_q    <= 1'b0;
            rx_thr_q <= '0;
            tx_thr_q <= '0;
        end else begin
            clr_q <= 1'b0;
            if (host_we && addr == A_CTRL) begin
                dir_q <= dir_e'(host_wdata[0]);
                clr_q <= host_wdata[1];
            end
            if (host_we && addr == A_THR) begin
                rx_thr_q <= host_wdata[LW-1:0];
                tx_thr_q <= host_wdata[THR_TX_LSB +: LW];
            end
        end
    end

    lrf_store #(.DEPTH(DEPTH), .AW(AW), .LW(LW)) u_store (
        .clk(clk), .rst(rst), .flush(clr_q),
        .push(push), .wbyte(wbyte), .pop(pop),
        .head(head), .count(level)
    );

    lrf_req #(.LW(LW), .INCL(INCL)) u_req (
        .dir(dir_q), .level(level), .rx_thr(rx_thr_q), .tx_thr(tx_thr_q),
        .req(req_now)
    );

    always_comb begin
        ev           = '0;
        ev.illegal   = ill_ev;
        ev.overflow  = ovf_ev;
        ev.underflow = udf_ev;
        ev.request   = req_now;
    end

    lrf_status u_status (
        .clk(clk), .rst(rst), .ev(ev), .clr_we(stat_wr),
        .clr_mask(host_wdata[ST_W-1:0]), .st(st_bits)
    );

    assign st  = stat_t'(st_bits);
    assign irq = |st_bits;

    assign eng_rdata = (dir_q == DIR_TX && !empty) ? head : '0;

    always_comb begin
        host_rdata = '0;
        case (addr)
            A_CTRL: host_rdata[1:0] = {clr_q, dir_q};
            A_THR: begin
                host_rdata[LW-1:0]              = rx_thr_q;
                host_rdata[THR_TX_LSB +: LW]    = tx_thr_q;
            end
            A_STAT: host_rdata[ST_W-1:0] = st_bits;
            default: host_rdata = (dir_q == DIR_RX && !empty) ? zext_byte(head) : '0;
        endcase
    end

    assert_ovf_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_ev && !stat_wr) |=> st.overflow)
        else $error("overflow not flagged");

    assert_ovf_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_ev && !eng_pop) |=> $stable(level))
        else $error("level moved on overflow");

    assert_udf_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (udf_ev && !stat_wr) |=> st.underflow)
        else $error("underflow not flagged");

    assert_ill_flag_R5: assert property (@(posedge clk) disable iff (rst)
        (ill_ev && !stat_wr) |=> st.illegal)
        else $error("illegal access not flagged");
endmodule

// File: tb/tb_lvl_req_fifo.sv
module tb_lvl_req_fifo;
    import lrf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_we = 0, host_re = 0, eng_push = 0, eng_pop = 0;
    logic [1:0]  host_addr = 0;
    logic [15:0] host_wdata = 0;
    logic [7:0]  eng_wdata = 0;
    logic [15:0] rd_x, rd_i;
    logic [7:0]  er_x, er_i;
    logic [4:0]  lv_x, lv_i;
    logic        irq_x, irq_i;
    int nvec = 0, nfail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lvl_req_fifo #(.DEPTH(16), .INCL(1'b0)) dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rd_x),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .eng_rdata(er_x), .level(lv_x), .irq(irq_x));

    lvl_req_fifo #(.DEPTH(16), .INCL(1'b1)) dut_i (
        .clk(clk), .rst(rst), .host_we(host_we), .host_re(host_re),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(rd_i),
        .eng_push(eng_push), .eng_wdata(eng_wdata), .eng_pop(eng_pop),
        .eng_rdata(er_i), .level(lv_i), .irq(irq_i));

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        host_we = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        host_re = 1; host_addr = a;
        #1 v = rd_x;
        @(negedge clk);
        host_re = 0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] vx, output logic [15:0] vi);
        host_addr = a;
        #1 vx = rd_x; vi = rd_i;
    endtask

    task automatic e_push(input logic [7:0] b);
        @(negedge clk);
        eng_push = 1; eng_wdata = b;
        @(negedge clk);
        eng_push = 0;
    endtask

    task automatic e_pop(output logic [7:0] b);
        @(negedge clk);
        eng_pop = 1;
        #1 b = er_x;
        @(negedge clk);
        eng_pop = 0;
    endtask

    task automatic clr_stat();
        host_wr(2'd2, 16'h000F);
    endtask

    task automatic flush_dir(input logic d);
        host_wr(2'd0, {14'd0, 1'b1, d});
        idle(2);
    endtask

    task automatic t_reset();
        logic [15:0] a, b;
        peek(2'd0, a, b); chk("R1 ctrl", a, 16'h0);
        peek(2'd1, a, b); chk("R1 thr", a, 16'h0);
        peek(2'd2, a, b); chk("R1 status", a, 16'h0);
        chk("R1 level", 16'(lv_x), 16'h0);
        chk("R1 irq", 16'(irq_x), 16'h0);
    endtask

    task automatic t_tx_order();
        logic [7:0] b;
        host_wr(2'd3, 16'h00A1);
        host_wr(2'd3, 16'h00B2);
        host_wr(2'd3, 16'h00C3);
        chk("R2 tx level", 16'(lv_x), 16'd3);
        e_pop(b); chk("R2 R12 tx byte0", 16'(b), 16'h00A1);
        e_pop(b); chk("R2 R12 tx byte1", 16'(b), 16'h00B2);
        e_pop(b); chk("R2 R12 tx byte2", 16'(b), 16'h00C3);
        chk("R2 tx drained", 16'(lv_x), 16'd0);
    endtask

    task automatic t_tx_request();
        logic [15:0] a, b;
        host_wr(2'd1, 16'h0200);
        clr_stat(); idle(1);
        peek(2'd2, a, b); chk("R8 empty below thr", a & 16'h1, 16'h1);
        host_wr(2'd3, 16'h0011);
        host_wr(2'd3, 16'h0022);
        clr_stat(); idle(2);
        peek(2'd2, a, b);
        chk("R8 strict at thr", a & 16'h1, 16'h0);
        chk("R8 inclusive at thr", b & 16'h1, 16'h1);
    endtask

    task automatic t_reassert();
        logic [15:0] a, b;
        host_wr(2'd1, 16'h0300);
        idle(1);
        clr_stat();
        peek(2'd2, a, b); chk("R10 cleared cycle", a & 16'h1, 16'h0);
        idle(1);
        peek(2'd2, a, b); chk("R10 reasserted", a & 16'h1, 16'h1);
        flush_dir(1'b0);
    endtask

    task automatic t_overflow();
        logic [15:0] a, b;
        logic [7:0] e;
        flush_dir(1'b0);
        clr_stat();
        for (int k = 0; k < 16; k++) host_wr(2'd3, 16'(8'h10 + k));
        chk("R2 full level", 16'(lv_x), 16'd16);
        host_wr(2'd3, 16'h00EE);
        peek(2'd2, a, b);
        chk("R3 overflow flag", a & 16'h4, 16'h4);
        chk("R3 level held", 16'(lv_x), 16'd16);
        for (int k = 0; k < 16; k++) begin
            e_pop(e);
            if (e !== 8'(8'h10 + k)) chk("R3 R2 drain order", 16'(e), 16'(8'h10 + k));
        end
        chk("R3 dropped byte absent", 16'(lv_x), 16'd0);
        e_pop(e); chk("R12 pop empty gives 0", 16'(e), 16'h0);
    endtask

    task automatic t_underflow();
        logic [15:0] a, b, v;
        flush_dir(1'b1);
        clr_stat();
        host_rd(2'd3, v);
        chk("R4 underflow data", v, 16'h0);
        peek(2'd2, a, b);
        chk("R4 underflow flag", a & 16'h2, 16'h2);
    endtask

    task automatic t_rx();
        logic [15:0] a, b, v;
        host_wr(2'd1, 16'h0002);
        e_push(8'h5A);
        e_push(8'hA5);
        clr_stat(); idle(1);
        peek(2'd2, a, b);
        chk("R7 strict at thr", a & 16'h1, 16'h0);
        chk("R7 inclusive at thr", b & 16'h1, 16'h1);
        e_push(8'h3C); idle(1);
        peek(2'd2, a, b);
        chk("R7 strict above thr", a & 16'h1, 16'h1);
        host_rd(2'd3, v); chk("R2 R12 rx byte0", v, 16'h005A);
        host_rd(2'd3, v); chk("R2 R12 rx byte1", v, 16'h00A5);
        host_rd(2'd3, v); chk("R2 R12 rx byte2", v, 16'h003C);
        chk("R2 rx drained", 16'(lv_x), 16'd0);
    endtask

    task automatic t_illegal();
        logic [15:0] a, b, v;
        logic [7:0] e;
        e_push(8'h66);
        clr_stat();
        host_wr(2'd3, 16'h0077);
        peek(2'd2, a, b);
        chk("R5 write in rx flagged", a & 16'h8, 16'h8);
        chk("R5 write in rx level", 16'(lv_x), 16'd1);
        host_rd(2'd3, v); chk("R5 rx content kept", v, 16'h0066);
        host_wr(2'd0, 16'h0000);
        host_wr(2'd3, 16'h0042);
        clr_stat();
        host_rd(2'd3, v);
        chk("R5 read in tx data", v, 16'h0);
        peek(2'd2, a, b);
        chk("R5 read in tx flagged", a & 16'h8, 16'h8);
        chk("R5 read in tx level", 16'(lv_x), 16'd1);
        e_pop(e); chk("R5 tx content kept", 16'(e), 16'h0042);
        eng_wdata = 8'h99;
        e_push(8'h99);
        chk("R12 engine push in tx ignored", 16'(lv_x), 16'd0);
    endtask

    task automatic t_w1c();
        logic [15:0] a, b, v;
        flush_dir(1'b1);
        clr_stat();
        host_rd(2'd3, v);
        host_wr(2'd3, 16'h0001);
        peek(2'd2, a, b);
        chk("R9 both set", a & 16'hA, 16'hA);
        host_wr(2'd2, 16'h0008);
        peek(2'd2, a, b);
        chk("R9 partial clear", a & 16'hA, 16'h2);
    endtask

    task automatic t_clear();
        logic [15:0] a, b;
        host_wr(2'd0, 16'h0000);
        host_wr(2'd3, 16'h0001);
        host_wr(2'd3, 16'h0002);
        host_wr(2'd3, 16'h0003);
        host_wr(2'd0, 16'h0002);
        peek(2'd0, a, b);
        chk("R6 clear reads 1", a & 16'h2, 16'h2);
        idle(1);
        peek(2'd0, a, b);
        chk("R6 clear self-clears", a & 16'h2, 16'h0);
        chk("R6 level emptied", 16'(lv_x), 16'd0);
    endtask

    task automatic t_irq();
        logic [15:0] v;
        host_wr(2'd1, 16'h0000);
        clr_stat(); idle(2);
        chk("R11 irq low", 16'(irq_x), 16'h0);
        host_rd(2'd3, v);
        chk("R11 irq high", 16'(irq_x), 16'h1);
    endtask

    initial begin
        #150000;
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_tx_order();
        t_tx_request();
        t_reassert();
        t_overflow();
        t_underflow();
        t_rx();
        t_illegal();
        t_w1c();
        t_clear();
        t_irq();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule